// File: doc/BRIEF.md
# RC5 Infrared Frame Decoder

This block turns the output of an infrared receiver module into decoded RC5 remote-control words. The receiver has already removed the carrier, so the input `ir_n` is the active-low envelope. It is low while a burst is present and high while the line is quiet. The input first passes through a two-flop synchronizer and a short glitch filter. A time-based Manchester decoder then recovers the 14-bit frame, using a bit period that is derived from the clock frequency and the nominal bit length.

The decoder first sees activity at the falling edge of `ir_n` in the middle of the first start bit. It starts its bit timing from that edge and samples each bit at one quarter and at three quarters of the bit period. A well-formed word with both start bits at 1 produces a single-cycle `frame_valid` pulse, together with the toggle flag, the 5-bit address and the 6-bit command. Several faults abort the frame and produce a single-cycle `frame_error` pulse instead:

- a bit whose two halves carry the same level,
- a start bit that decodes as 0,
- a line that goes quiet part-way through the frame.

After either outcome, the decoder waits for a stretch of quiet line before it accepts the next frame.

Top module: `rc5_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `frame_valid` and `frame_error` are 0 and `toggle`, `address` and `command` are all 0.
- R2: A well-formed frame produces exactly one `frame_valid` pulse, one clock cycle wide, and no `frame_error`. `toggle`, `address` and `command` change only in the cycle in which `frame_valid` is 1, and they hold their values until the next valid frame.
- R3: A frame is 14 bits, sent first to last in this order: start bit 1, start bit 2, toggle, 5 address bits (most significant first), 6 command bits (most significant first).
- R4: A bit lasts CLK_HZ*BIT_PERIOD_NS/1e9 clock cycles. A logic 1 is `ir_n` high in the first half and low in the second half; a logic 0 is the reverse. The first falling edge of `ir_n` on an idle line is taken as the middle of the first start bit.
- R5: A frame whose second start bit decodes as 0 gives one `frame_error` pulse and no `frame_valid`.
- R6: A bit with no level change between its halves gives one `frame_error` pulse and no `frame_valid`. A frame that stops part-way, leaving the line quiet, gives one `frame_error` pulse no later than two bit periods after the last burst.
- R7: An `ir_n` pulse shorter than GLITCH_CYC clock cycles has no effect, whether it arrives on an idle line or inside a frame.
- R8: After a `frame_valid` or `frame_error` pulse, the decoder ignores `ir_n` until the line has been quiet (high) for at least 1.25 bit periods. A frame that starts earlier than that is dropped without any pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_n | input | 1 | Demodulated receiver output, low while a burst is present |
| frame_valid | output | 1 | One-cycle pulse when a frame decodes correctly |
| frame_error | output | 1 | One-cycle pulse when a frame is aborted |
| toggle | output | 1 | Toggle flag of the last valid frame |
| address | output | 5 | Address field of the last valid frame |
| command | output | 6 | Command field of the last valid frame |

## Verification
The bench uses a small bit period. It sweeps all 64 command values and all 32 address values with both toggle states, so that any swap, shift or reversal of bit order between the fields shows up as a wrong field value.

Error handling is tried with four corrupted patterns:

- a zero second start bit,
- a bit that holds its burst through both halves,
- a frame cut short after seven bits,
- single-cycle glitches, both on an idle line and inside a frame.

These patterns separate rejection of the start bits, checking of the Manchester transitions, and filtering of the input. A second frame sent back-to-back with a first one, followed by a frame sent after a proper gap, separates the quiet-line lockout from ordinary decoding.

// File: rtl/rc5_pkg.sv
package rc5_pkg;
   localparam int FRAME_BITS = 14;
   localparam int START_BITS = 2;
   localparam int ADDR_W     = 5;
   localparam int CMD_W      = 6;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RX    = 2'd1,
      ST_QUIET = 2'd2
   } rx_state_t;

   typedef struct packed {
      logic              toggle;
      logic [ADDR_W-1:0] addr;
      logic [CMD_W-1:0]  cmd;
   } rc5_fields_t;
endpackage

// File: rtl/rc5_line_cond.sv
module rc5_line_cond #(
   parameter int GLITCH_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ir_n,
   output logic burst
);
   logic [1:0] sync_q;
   logic       clean_n;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], ir_n};
   end

   generate
      if (GLITCH_CYC < 2) begin : g_no_filter
         assign clean_n = sync_q[1];
      end else begin : g_filter
         localparam int CW = $clog2(GLITCH_CYC);
         localparam logic [CW-1:0] C_LAST = CW'(GLITCH_CYC - 1);
         logic [CW-1:0] run_q;
         logic          level_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q   <= '0;
               level_q <= 1'b1;
            end else if (sync_q[1] == level_q) begin
               run_q <= '0;
            end else if (run_q == C_LAST) begin
               run_q   <= '0;
               level_q <= sync_q[1];
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
         assign clean_n = level_q;
      end
   endgenerate

   assign burst = ~clean_n;
endmodule

// File: rtl/rc5_frame_fsm.sv
module rc5_frame_fsm
   import rc5_pkg::*;
#(
   parameter int BIT_CYC = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  burst,
   output logic                  word_done,
   output logic                  word_err,
   output logic [FRAME_BITS-1:0] word
);
   localparam int QUIET_CYC = BIT_CYC + BIT_CYC / 4;
   localparam int PW        = $clog2(QUIET_CYC + 1);
   localparam int IW        = $clog2(FRAME_BITS);
   localparam logic [PW-1:0] P_LAST  = PW'(BIT_CYC - 1);
   localparam logic [PW-1:0] P_Q1    = PW'(BIT_CYC / 4);
   localparam logic [PW-1:0] P_Q3    = PW'((3 * BIT_CYC) / 4);
   localparam logic [PW-1:0] P_ENTRY = PW'(BIT_CYC / 2 + 1);
   localparam logic [PW-1:0] P_QUIET = PW'(QUIET_CYC - 1);
   localparam logic [IW-1:0] I_LAST  = IW'(FRAME_BITS - 1);
   localparam logic [IW-1:0] I_START = IW'(START_BITS);

   rx_state_t             state_q;
   logic [PW-1:0]         phase_q;
   logic [IW-1:0]         idx_q;
   logic                  early_q;
   logic                  prev_q;
   logic [FRAME_BITS-1:0] shift_q;
   logic                  bit_val;
   logic                  halves_differ;
   logic                  start_bad;

   always_comb begin
      halves_differ = early_q ^ burst;
      bit_val       = ~early_q & burst;
      start_bad     = (idx_q < I_START) && !bit_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         phase_q   <= '0;
         idx_q     <= '0;
         early_q   <= 1'b0;
         prev_q    <= 1'b0;
         shift_q   <= '0;
         word_done <= 1'b0;
         word_err  <= 1'b0;
      end else begin
         word_done <= 1'b0;
         word_err  <= 1'b0;
         prev_q    <= burst;
         unique case (state_q)
            ST_IDLE: begin
               if (burst && !prev_q) begin
                  state_q <= ST_RX;
                  phase_q <= P_ENTRY;
                  idx_q   <= '0;
                  early_q <= 1'b0;
               end
            end
            ST_RX: begin
               if (phase_q == P_LAST) begin
                  phase_q <= '0;
                  idx_q   <= idx_q + 1'b1;
               end else begin
                  phase_q <= phase_q + 1'b1;
               end
               if (phase_q == P_Q1) early_q <= burst;
               if (phase_q == P_Q3) begin
                  if (!halves_differ || start_bad) begin
                     word_err <= 1'b1;
                     state_q  <= ST_QUIET;
                     phase_q  <= '0;
                  end else begin
                     shift_q <= {shift_q[FRAME_BITS-2:0], bit_val};
                     if (idx_q == I_LAST) begin
                        word_done <= 1'b1;
                        state_q   <= ST_QUIET;
                        phase_q   <= '0;
                     end
                  end
               end
            end
            ST_QUIET: begin
               if (burst)                  phase_q <= '0;
               else if (phase_q == P_QUIET) state_q <= ST_IDLE;
               else                        phase_q <= phase_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign word = shift_q;
endmodule

// File: rtl/rc5_field_reg.sv
module rc5_field_reg
   import rc5_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  word_done,
   input  logic                  word_err,
   input  logic [FRAME_BITS-1:0] word,
   output logic                  frame_valid,
   output logic                  frame_error,
   output rc5_fields_t           fields
);
   rc5_fields_t unpacked;

   always_comb begin
      unpacked.toggle = word[ADDR_W + CMD_W];
      unpacked.addr   = word[CMD_W +: ADDR_W];
      unpacked.cmd    = word[0 +: CMD_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_valid <= 1'b0;
         frame_error <= 1'b0;
         fields      <= '0;
      end else begin
         frame_valid <= word_done;
         frame_error <= word_err;
         if (word_done) fields <= unpacked;
      end
   end
endmodule

// File: rtl/rc5_decoder.sv
module rc5_decoder
   import rc5_pkg::*;
#(
   parameter longint unsigned CLK_HZ        = 64'd48_000_000,
   parameter longint unsigned BIT_PERIOD_NS = 64'd1_778_000,
   parameter int              GLITCH_CYC    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ir_n,
   output logic              frame_valid,
   output logic              frame_error,
   output logic              toggle,
   output logic [ADDR_W-1:0] address,
   output logic [CMD_W-1:0]  command
);
   localparam int BIT_CYC = int'((CLK_HZ * BIT_PERIOD_NS) / 64'd1_000_000_000);

   generate
      if (BIT_CYC < 16) begin : g_bad_period
         $error("rc5_decoder: bit period must span at least 16 clock cycles");
      end
      if (GLITCH_CYC * 8 > BIT_CYC) begin : g_bad_glitch
         $error("rc5_decoder: glitch filter must stay under one eighth of a bit");
      end
   endgenerate

   logic                  burst;
   logic                  word_done;
   logic                  word_err;
   logic [FRAME_BITS-1:0] word;
   rc5_fields_t           fields;

   rc5_line_cond #(.GLITCH_CYC(GLITCH_CYC)) i_line (
      .clk   (clk),
      .rst_n (rst_n),
      .ir_n  (ir_n),
      .burst (burst)
   );

   rc5_frame_fsm #(.BIT_CYC(BIT_CYC)) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .burst     (burst),
      .word_done (word_done),
      .word_err  (word_err),
      .word      (word)
   );

   rc5_field_reg i_fields (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_done   (word_done),
      .word_err    (word_err),
      .word        (word),
      .frame_valid (frame_valid),
      .frame_error (frame_error),
      .fields      (fields)
   );

   assign toggle  = fields.toggle;
   assign address = fields.addr;
   assign command = fields.cmd;
endmodule

// File: rtl/rc5_decoder_checker.sv
module rc5_decoder_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_valid,
   input logic       frame_error,
   input logic       toggle,
   input logic [4:0] address,
   input logic [5:0] command
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!frame_valid && !frame_error && {toggle, address, command} == 12'd0));

   assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   assert_fields_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> $stable({toggle, address, command}));

   assert_error_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_error |=> !frame_error);

   assert_outcome_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_valid && frame_error));

   assert_lockout_after_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> (!frame_valid && !frame_error));
endmodule

bind rc5_decoder rc5_decoder_checker i_rc5_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_valid (frame_valid),
   .frame_error (frame_error),
   .toggle      (toggle),
   .address     (address),
   .command     (command)
);

// File: tb/test_rc5_decoder.sv
module test_rc5_decoder;
   localparam int BIT_CYC = 32;
   localparam int HALF    = BIT_CYC / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ir_n = 1'b1;
   logic       frame_valid;
   logic       frame_error;
   logic       toggle;
   logic [4:0] address;
   logic [5:0] command;

   int checks = 0;
   int errors = 0;
   int vcnt = 0;
   int ecnt = 0;
   logic [11:0] got_fields = '0;

   always #2 clk = ~clk;

   rc5_decoder #(
      .CLK_HZ        (64'd250_000_000),
      .BIT_PERIOD_NS (64'd128),
      .GLITCH_CYC    (2)
   ) i_rc5_decoder (
      .clk         (clk),
      .rst_n       (rst_n),
      .ir_n        (ir_n),
      .frame_valid (frame_valid),
      .frame_error (frame_error),
      .toggle      (toggle),
      .address     (address),
      .command     (command)
   );

   always @(negedge clk) begin
      if (rst_n && frame_valid) begin
         vcnt = vcnt + 1;
         got_fields = {toggle, address, command};
      end
      if (rst_n && frame_error) ecnt = ecnt + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // One bit: glitch_on inserts a one-cycle inversion in the first half,
   // flat holds the burst through both halves.
   task automatic send_bit(input logic b, input bit glitch_on, input bit flat);
      logic h1;
      h1 = b ? 1'b1 : 1'b0;
      if (flat) h1 = 1'b0;
      if (glitch_on) begin
         ir_n = h1;  repeat (5) @(negedge clk);
         ir_n = ~h1; repeat (1) @(negedge clk);
         ir_n = h1;  repeat (HALF - 6) @(negedge clk);
      end else begin
         ir_n = h1;  repeat (HALF) @(negedge clk);
      end
      ir_n = flat ? 1'b0 : ~h1;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic send_frame(input logic [13:0] w, input int nbits, input int bad, input int glitch);
      for (int i = 0; i < nbits; i++) send_bit(w[13 - i], (i == glitch), (i == bad));
      ir_n = 1'b1;
   endtask

   task automatic settle();
      repeat (2 * BIT_CYC) @(negedge clk);
   endtask

   function automatic logic [13:0] mk(input logic s2, input logic t, input logic [4:0] a, input logic [5:0] c);
      return {1'b1, s2, t, a, c};
   endfunction

   task automatic good_frame(input logic t, input logic [4:0] a, input logic [5:0] c, input int glitch, input string req);
      vcnt = 0; ecnt = 0;
      send_frame(mk(1'b1, t, a, c), 14, -1, glitch);
      settle();
      check(vcnt == 1 && ecnt == 0, req, vcnt * 16 + ecnt, 16);
      check(got_fields == {t, a, c}, req, int'(got_fields), int'({t, a, c}));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      check(!frame_valid && !frame_error && {toggle, address, command} == 12'd0, "R1 in reset",
            int'({frame_valid, frame_error, toggle, address, command}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!frame_valid && !frame_error && {toggle, address, command} == 12'd0, "R1 after release",
            int'({frame_valid, frame_error, toggle, address, command}), 0);
      settle();

      // R2 R3 R4: all commands, varied address and toggle
      for (int c = 0; c < 64; c++)
         good_frame(c[0], 5'(c) ^ 5'h15, 6'(c), -1, "R3 command sweep");
      // R3 R4: all addresses
      for (int a = 0; a < 32; a++)
         good_frame(a[1], 5'(a), ~{5'(a), 1'b1}, -1, "R3 address sweep");
      good_frame(1'b0, 5'h00, 6'h00, -1, "R4 all zero");
      good_frame(1'b1, 5'h1f, 6'h3f, -1, "R4 all one");

      // R5: second start bit 0
      vcnt = 0; ecnt = 0;
      send_frame(mk(1'b0, 1'b1, 5'h0a, 6'h2b), 14, -1, -1);
      settle();
      check(ecnt == 1 && vcnt == 0, "R5 bad start", ecnt * 16 + vcnt, 16);
      check(got_fields == {1'b1, 5'h1f, 6'h3f}, "R5 fields kept", int'(got_fields), 12'hfff);

      // R6: bit 7 without mid-bit change
      vcnt = 0; ecnt = 0;
      send_frame(mk(1'b1, 1'b0, 5'h11, 6'h22), 14, 7, -1);
      settle();
      check(ecnt == 1 && vcnt == 0, "R6 missing transition", ecnt * 16 + vcnt, 16);

      // R6: frame stops after seven bits
      vcnt = 0; ecnt = 0;
      send_frame(mk(1'b1, 1'b1, 5'h07, 6'h15), 7, -1, -1);
      settle();
      check(ecnt == 1 && vcnt == 0, "R6 truncated frame", ecnt * 16 + vcnt, 16);
      settle();

      // R7: glitch on idle line, then glitches inside frames
      vcnt = 0; ecnt = 0;
      ir_n = 1'b0; @(negedge clk); ir_n = 1'b1;
      settle();
      check(vcnt == 0 && ecnt == 0, "R7 idle glitch", vcnt * 16 + ecnt, 0);
      good_frame(1'b1, 5'h13, 6'h2d, 4, "R7 glitch in frame");
      good_frame(1'b0, 5'h0c, 6'h31, 11, "R7 glitch late in frame");

      // R8: back-to-back frame is dropped, spaced frame decodes
      vcnt = 0; ecnt = 0;
      send_frame(mk(1'b1, 1'b0, 5'h05, 6'h01), 14, -1, -1);
      send_frame(mk(1'b1, 1'b1, 5'h1a, 6'h3c), 14, -1, -1);
      settle();
      check(vcnt == 1 && ecnt == 0, "R8 lockout count", vcnt * 16 + ecnt, 16);
      check(got_fields == {1'b0, 5'h05, 6'h01}, "R8 lockout fields", int'(got_fields), int'({1'b0, 5'h05, 6'h01}));
      good_frame(1'b1, 5'h1a, 6'h3c, -1, "R8 recovery");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule